// File: doc/BRIEF.md
# Burst-of-four DDR SRAM core model

A synthesizable, single-clock model of a double-data-rate SRAM that moves four words per command. The block runs at twice the K rate, and its ticks alternate between K and K# edges. The first edge after reset is a K edge. The `k_tick` output is high during a tick whose closing edge is a K edge, so the host knows where to place commands.

Commands are taken on K edges. A write collects four words, each with its own byte enables, over the next two K periods. A read returns four words on consecutive half-cycles after a fixed latency. During those four words the output enable is raised. At all other times the data output is forced to zero with the enable low, which stands in for a floating bus.

Bursts may start at any word of an aligned group of four. They wrap inside that group. A free-running counter raises a one-tick flag that stands in for periodic drive-strength recalibration. A saturating counter records loads that arrive while a burst still owns the command slot.

Top module: `ddr4b_sram`

## Requirements
- R1: A command is accepted only at a K edge where `ld_n` is 0. `rw`=1 selects read and `rw`=0 selects write, and `addr` is sampled at that same edge. The first edge after reset is a K edge, and `k_tick` is 1 during ticks that end in a K edge. A load on a K# edge has no effect: it writes nothing and the error count does not change.
- R2: For a write accepted at edge t, the four data words are sampled from `d` at edges t+2, t+3, t+4 and t+5.
- R3: Each write word uses the `be` value sampled with it. Bit i of `be` enables bits [9i+8:9i] of the word, and a byte whose bit is 0 keeps its stored value. With `be`=0 the whole word is skipped.
- R4: Word k of a burst (k=0..3) goes to address {addr[AW-1:2], (addr[1:0]+k) mod 4}. The upper address bits never change during a burst.
- R5: For a read accepted at edge t, word k is registered onto `q` at edge t+LAT_HALF+k. The default LAT_HALF is 3, so the first word appears on a K# edge. Words follow the same wrapped order as writes.
- R6: `q_oe` is 1 exactly while read words are held on `q`. Whenever `q_oe` is 0, `q` is 0. Both are 0 after reset.
- R7: `cal_upd` pulses high for one tick every CAL_K K edges. The first pulse follows the CAL_K-th K edge after reset. With the default CAL_K of 1024, pulses are 2048 ticks apart.
- R8: A load at the K edge right after an accepted command is ignored. It writes nothing, starts no read, and adds 1 to `err_cnt`, which saturates at its maximum.
- R9: A new command may follow every second K edge. A read issued right after a write to the same group returns the new data. A write issued right after a read changes none of that read's words, even when its first word hits the address of the read's last word at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; edges alternate K and K# |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_tick | output | 1 | High when the next edge is a K edge |
| ld_n | input | 1 | Active-low load strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address |
| d | input | W | Write data word |
| be | input | W/LANE | Per-byte write enables for the current word |
| q | output | W | Read data word, 0 when not enabled |
| q_oe | output | 1 | Read data output enable |
| cal_upd | output | 1 | One-tick recalibration flag |
| err_cnt | output | ECW | Saturating count of ignored loads |

## Verification
The last read word and the first write word can land on the same edge. This happens when a read is followed at the next allowed K edge by a write whose start address is the read address plus three. The bench sets up exactly that overlap. It then checks that the read's fourth word still carries the value stored before the write. A later read must show the written data in wrapped order. The bench also places a rejected load inside a live read burst and checks that the read data, the idle enable and the target group are all undisturbed.

// File: rtl/ddr4b_sram.sv
module ddr4b_sram #(
  parameter int W        = 18,
  parameter int LANE     = 9,
  parameter int AW       = 8,
  parameter int LAT_HALF = 3,
  parameter int CAL_K    = 1024,
  parameter int ECW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              k_tick,
  input  logic              ld_n,
  input  logic              rw,
  input  logic [AW-1:0]     addr,
  input  logic [W-1:0]      d,
  input  logic [W/LANE-1:0] be,
  output logic [W-1:0]      q,
  output logic              q_oe,
  output logic              cal_upd,
  output logic [ECW-1:0]    err_cnt
);
  localparam int NB    = W / LANE;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(CAL_K);
  localparam bit OE_PH = ((LAT_HALF + 1) % 2) == 1;

  logic [W-1:0] mem [DEPTH];

  logic ph, hold, acc;
  logic [LAT_HALF-1:0]         rv;
  logic [LAT_HALF-1:0][AW-1:0] ra;
  logic [1:0]                  wv;
  logic [1:0][AW-1:0]          wa;
  logic          wact, oact;
  logic [1:0]    wbeat, obeat;
  logic [AW-1:0] wbase, obase;
  logic [CW-1:0] ccnt;

  assign k_tick = ~ph;
  assign acc    = ~ph & ~ld_n & ~hold;

  wire          wen   = wv[1] | wact;
  wire [AW-1:0] wsel  = wv[1] ? wa[1] : wbase;
  wire [1:0]    wk    = wv[1] ? 2'd0 : wbeat;
  wire [AW-1:0] waddr = {wsel[AW-1:2], 2'(wsel[1:0] + wk)};

  wire          ren   = rv[LAT_HALF-1] | oact;
  wire [AW-1:0] rsel  = rv[LAT_HALF-1] ? ra[LAT_HALF-1] : obase;
  wire [1:0]    rk    = rv[LAT_HALF-1] ? 2'd0 : obeat;
  wire [AW-1:0] raddr = {rsel[AW-1:2], 2'(rsel[1:0] + rk)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      hold    <= 1'b0;
      err_cnt <= '0;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        if (hold) begin
          hold <= 1'b0;
          if (!ld_n && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
        end else if (!ld_n) begin
          hold <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv <= '0;
      ra <= '0;
      wv <= '0;
      wa <= '0;
    end else begin
      rv[0] <= acc & rw;
      ra[0] <= addr;
      for (int i = 1; i < LAT_HALF; i++) begin
        rv[i] <= rv[i-1];
        ra[i] <= ra[i-1];
      end
      wv <= {wv[0], acc & ~rw};
      wa <= {wa[0], addr};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wact  <= 1'b0;
      wbeat <= '0;
      wbase <= '0;
    end else if (wv[1]) begin
      wact  <= 1'b1;
      wbeat <= 2'd1;
      wbase <= wa[1];
    end else if (wact) begin
      wbeat <= wbeat + 2'd1;
      if (wbeat == 2'd3) wact <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wen)
      for (int b = 0; b < NB; b++)
        if (be[b]) mem[waddr][b*LANE +: LANE] <= d[b*LANE +: LANE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oact  <= 1'b0;
      obeat <= '0;
      obase <= '0;
      q     <= '0;
      q_oe  <= 1'b0;
    end else begin
      q    <= ren ? mem[raddr] : '0;
      q_oe <= ren;
      if (rv[LAT_HALF-1]) begin
        oact  <= 1'b1;
        obeat <= 2'd1;
        obase <= ra[LAT_HALF-1];
      end else if (oact) begin
        obeat <= obeat + 2'd1;
        if (obeat == 2'd3) oact <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt    <= '0;
      cal_upd <= 1'b0;
    end else begin
      cal_upd <= 1'b0;
      if (!ph) begin
        if (ccnt == CW'(CAL_K - 1)) begin
          ccnt    <= '0;
          cal_upd <= 1'b1;
        end else begin
          ccnt <= ccnt + 1'b1;
        end
      end
    end
  end

  p_oe_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_oe) |-> ph == OE_PH);

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !q_oe |-> q == '0);

  p_err_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt >= $past(err_cnt));

  p_cal_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_upd |=> !cal_upd);

  p_burst_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oact && obeat == 2'd3 && !rv[LAT_HALF-1]) |=> (q_oe && !oact));

endmodule

// File: tb/test_ddr4b_sram.sv
`timescale 1ns/1ps
module test_ddr4b_sram;
  logic clk = 0, rst_n = 0;
  logic ld_n = 1, rw = 0;
  logic [7:0] addr = '0;
  logic [17:0] d = '0;
  logic [1:0] be = '0;
  logic k_tick, q_oe, cal_upd;
  logic [17:0] q;
  logic [7:0] err_cnt;

  int tests = 0, fails = 0;
  logic [17:0] model [256];
  int tick = 0, r1 = -1, r2 = -1;
  bit prev_cal = 0, wide = 0;

  ddr4b_sram i_ddr4b_sram (.clk(clk), .rst_n(rst_n), .k_tick(k_tick), .ld_n(ld_n),
    .rw(rw), .addr(addr), .d(d), .be(be), .q(q), .q_oe(q_oe),
    .cal_upd(cal_upd), .err_cnt(err_cnt));

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) tick++;

  always @(negedge clk) if (rst_n) begin
    if (cal_upd && !prev_cal) begin
      if (r1 < 0) r1 = tick; else if (r2 < 0) r2 = tick;
    end
    if (cal_upd && prev_cal) wide = 1;
    prev_cal = cal_upd;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wadr(input logic [7:0] a, input int k);
    return {a[7:2], 2'(a[1:0] + 2'(k))};
  endfunction

  task automatic issue(input logic r, input logic [7:0] a);
    do @(negedge clk); while (!k_tick);
    ld_n = 0; rw = r; addr = a;
    @(negedge clk);
    ld_n = 1;
  endtask

  task automatic mupd(input logic [7:0] a, input logic [17:0] w, input logic [1:0] m);
    if (m[0]) model[a][8:0]  = w[8:0];
    if (m[1]) model[a][17:9] = w[17:9];
  endtask

  task automatic do_write(input logic [7:0] a, input logic [17:0] w [4], input logic [1:0] m [4]);
    issue(0, a);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); d = w[k]; be = m[k];
      mupd(wadr(a, k), w[k], m[k]);
    end
    @(negedge clk); be = 0;
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    issue(1, a);
    @(negedge clk); chk(q_oe === 0, req, q_oe, 0);
    @(negedge clk); chk(q_oe === 0, req, q_oe, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(q_oe === 1 && q === model[wadr(a, k)], req, q, model[wadr(a, k)]);
    end
    @(negedge clk); chk(q_oe === 0 && q === 0, req, q_oe, 0);
  endtask

  task automatic fill(input logic [7:0] a, input logic [17:0] seed);
    logic [17:0] w [4];
    logic [1:0] m [4];
    for (int k = 0; k < 4; k++) begin w[k] = seed + 18'(k * 18'h1111); m[k] = 2'b11; end
    do_write(a, w, m);
  endtask

  task automatic t_reset;
    chk(q_oe === 0 && q === 0, "R6 reset", q, 0);
    chk(err_cnt === 0, "R8 reset", err_cnt, 0);
    chk(k_tick === 1, "R1 first edge K", k_tick, 1);
  endtask

  task automatic t_aligned;
    fill(8'h10, 18'h01234);
    do_read(8'h10, "R2 R5 aligned");
  endtask

  task automatic t_wrap;
    fill(8'h24, 18'h0ABCD);
    fill(8'h22, 18'h20001);
    do_read(8'h20, "R4 wrap from 2");
    do_read(8'h23, "R4 read start 3");
    do_read(8'h24, "R4 upper untouched");
  endtask

  task automatic t_mask;
    logic [17:0] w [4];
    logic [1:0] m [4];
    fill(8'h30, 18'h15555);
    w = '{18'h3FFFF, 18'h00000, 18'h2AAAA, 18'h1F0F0};
    m = '{2'b01, 2'b10, 2'b00, 2'b11};
    do_write(8'h31, w, m);
    do_read(8'h30, "R3 byte mask");
  endtask

  task automatic t_kbar_load;
    logic [7:0] e0;
    e0 = err_cnt;
    do @(negedge clk); while (k_tick);
    ld_n = 0; rw = 0; addr = 8'h10; be = 2'b11; d = 18'h3FFFF;
    @(negedge clk); ld_n = 1;
    repeat (6) @(negedge clk);
    be = 0;
    chk(err_cnt === e0, "R1 K# load count", err_cnt, e0);
    chk(q_oe === 0, "R1 K# load no read", q_oe, 0);
    do_read(8'h10, "R1 K# load no write");
  endtask

  task automatic t_reject;
    logic [7:0] e0;
    fill(8'h50, 18'h0C0DE);
    e0 = err_cnt;
    issue(1, 8'h11);
    @(negedge clk); ld_n = 0; rw = 0; addr = 8'h50; be = 2'b11; d = 18'h3FFFF;
    chk(q_oe === 0, "R8 gap", q_oe, 0);
    @(negedge clk); ld_n = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(q_oe === 1 && q === model[wadr(8'h11, k)], "R8 read intact", q, model[wadr(8'h11, k)]);
    end
    @(negedge clk); be = 0;
    chk(q_oe === 0, "R8 no extra read", q_oe, 0);
    @(negedge clk); chk(q_oe === 0, "R8 no extra read", q_oe, 0);
    chk(err_cnt === e0 + 8'd1, "R8 err count", err_cnt, e0 + 8'd1);
    do_read(8'h50, "R8 no write");
  endtask

  task automatic t_wr_then_rd;
    logic [17:0] w [4];
    w = '{18'h11111, 18'h22222, 18'h33333, 18'h04444};
    issue(0, 8'h60);
    @(negedge clk); d = w[0]; be = 2'b11;
    @(negedge clk); d = w[1];
    @(negedge clk); d = w[2]; ld_n = 0; rw = 1; addr = 8'h60;
    @(negedge clk); d = w[3]; ld_n = 1;
    @(negedge clk); be = 0;
    for (int k = 0; k < 4; k++) mupd(8'h60 + 8'(k), w[k], 2'b11);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(q_oe === 1 && q === w[k], "R9 write then read", q, w[k]);
    end
  endtask

  task automatic t_rd_then_wr;
    logic [17:0] old [4];
    logic [17:0] w [4];
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) old[k] = model[8'h60 + 8'(k)];
    w = '{18'h0AAAA, 18'h0BBBB, 18'h0CCCC, 18'h0DDDD};
    issue(1, 8'h60);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(q === old[0], "R9 read before write", q, old[0]);
    ld_n = 0; rw = 0; addr = 8'h63;
    @(negedge clk); ld_n = 1;
    chk(q === old[1], "R9 read before write", q, old[1]);
    @(negedge clk); d = w[0]; be = 2'b11;
    chk(q === old[2], "R9 read before write", q, old[2]);
    @(negedge clk); d = w[1];
    chk(q_oe === 1 && q === old[3], "R9 same-edge collision", q, old[3]);
    @(negedge clk); d = w[2];
    @(negedge clk); d = w[3];
    @(negedge clk); be = 0;
    for (int k = 0; k < 4; k++) mupd(wadr(8'h63, k), w[k], 2'b11);
    do_read(8'h60, "R9 write after read");
  endtask

  task automatic t_cal;
    for (int i = 0; i < 6000 && r2 < 0; i++) @(negedge clk);
    chk(r1 == 2047, "R7 first pulse", r1, 2047);
    chk(r2 - r1 == 2048, "R7 period", r2 - r1, 2048);
    chk(!wide, "R7 one tick", wide, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset;
    t_aligned;
    t_wrap;
    t_mask;
    t_kbar_load;
    t_reject;
    t_wr_then_rd;
    t_rd_then_wr;
    t_cal;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule